// File: doc/BRIEF.md
# Banked Internal Data Memory Decoder

This block is the on-chip data memory of a small 8-bit controller core. It holds a 256-byte RAM and decides, for each access, whether the byte lives in that RAM or belongs to the special function register (SFR) file. The SFR file sits outside the block and is reached through a request port. For the range 80H to FFH the decision depends on the addressing mode. An indirect access reaches the upper half of the RAM. A direct access goes to the SFR port.

The core can also name one of eight working registers instead of giving an address. The block then places that register inside one of four 8-byte banks at the bottom of RAM. Two bank bits from the core's status word choose the bank. Reads are synchronous and take one cycle, and SFR read data comes back in that same slot. A reset clears the whole RAM to zero.

Top module: `idata_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, `rd_data` is 00H and `sfr_req` is 0. Every RAM byte reads as 00H after reset.
- R2: An address from 00H to 7FH reaches the same RAM byte whether `acc_indirect` is 0 (direct) or 1 (indirect).
- R3: An indirect access to an address from 80H to FFH reads or writes the upper RAM and raises no SFR request.
- R4: A direct access to an address from 80H to FFH raises `sfr_req` in the following cycle only. In that cycle `sfr_addr` is the access address, `sfr_we` equals the write strobe, and `sfr_wdata` holds the write data (00H on a read).
- R5: A direct access to 80H to FFH leaves the RAM byte at that address unchanged. An indirect read of that address afterwards returns its earlier value.
- R6: With `reg_mode` = 1, the operand Rn (`reg_sel` = n) reaches RAM address `bank_sel`*8 + n. `acc_addr` and `acc_indirect` are ignored, and no SFR request is raised.
- R7: A RAM read presents its byte on `rd_data` in the cycle after the read strobe. A write is visible to any later read.
- R8: For a direct read of 80H to FFH, `rd_data` in the following cycle equals `sfr_rdata` as driven during that cycle.
- R9: After a cycle with no read strobe, `rd_data` is 00H. When `rd_en` and `wr_en` are both 1, the access is a write only.
- R10: After a cycle with no direct access to 80H to FFH, `sfr_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the RAM and the outputs |
| acc_addr | input | 8 | Access address when not in register mode |
| acc_indirect | input | 1 | 1 = indirect addressing, 0 = direct |
| reg_mode | input | 1 | 1 = operand is a bank register selected by `reg_sel` |
| reg_sel | input | 3 | Register number n of Rn |
| bank_sel | input | 2 | Active bank from the status word |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after the read strobe |
| sfr_req | output | 1 | One-cycle request to the SFR file |
| sfr_we | output | 1 | SFR request is a write |
| sfr_addr | output | 8 | SFR address |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, sampled while `sfr_req` is high |

## Verification
The hardest case to reach is an address from 80H to FFH that has valid data in upper RAM and is also the target of a direct access. The test has to show both that the direct access went out on the SFR port and that the RAM byte at that address did not change. To do this, the stimulus first writes known patterns into upper RAM with indirect writes. It then issues direct writes and reads to the same addresses, and finally reads them back indirectly. Register operands are run through all four banks, and their results are cross-read with plain direct addresses. A long random phase then mixes all modes against the reference model.

// File: rtl/idm_pkg.sv
package idm_pkg;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 8;
    parameter int BANK_W = 2;
    parameter int REG_W  = 3;
    localparam int DEPTH = 1 << ADDR_W;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_SFR  = 2'd2
    } target_e;

    typedef struct packed {
        logic              rd_sfr;
        logic              sfr_req;
        logic              sfr_we;
        logic [ADDR_W-1:0] sfr_addr;
        logic [DATA_W-1:0] sfr_wdata;
    } port_state_t;
endpackage

// File: rtl/idm_addr_resolve.sv
module idm_addr_resolve
    import idm_pkg::*;
(
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_indirect,
    input  logic              reg_mode,
    input  logic [REG_W-1:0]  reg_sel,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              any_access,
    output target_e           target,
    output logic [ADDR_W-1:0] eff_addr
);
    localparam int PAD_W = ADDR_W - BANK_W - REG_W;

    logic upper_half;

    always_comb begin
        if (reg_mode) begin
            eff_addr = {{PAD_W{1'b0}}, bank_sel, reg_sel};
        end else begin
            eff_addr = acc_addr;
        end
        upper_half = eff_addr[ADDR_W-1];
        if (!any_access) begin
            target = TGT_NONE;
        end else if (upper_half && !acc_indirect && !reg_mode) begin
            target = TGT_SFR;
        end else begin
            target = TGT_RAM;
        end
    end
endmodule

// File: rtl/idm_ram.sv
module idm_ram
    import idm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_q
);
    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (we) begin
                cells[addr] <= wdata;
            end
            if (re) begin
                rdata_q <= cells[addr];
            end else begin
                rdata_q <= '0;
            end
        end
    end
endmodule

// File: rtl/idata_mem.sv
module idata_mem
    import idm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_indirect,
    input  logic              reg_mode,
    input  logic [REG_W-1:0]  reg_sel,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              sfr_req,
    output logic              sfr_we,
    output logic [ADDR_W-1:0] sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    target_e           target;
    logic [ADDR_W-1:0] eff_addr;
    logic              ram_we;
    logic              ram_re;
    logic [DATA_W-1:0] ram_rdata;
    port_state_t       st_d;
    port_state_t       st_q;

    idm_addr_resolve u_resolve (
        .acc_addr     (acc_addr),
        .acc_indirect (acc_indirect),
        .reg_mode     (reg_mode),
        .reg_sel      (reg_sel),
        .bank_sel     (bank_sel),
        .any_access   (rd_en | wr_en),
        .target       (target),
        .eff_addr     (eff_addr)
    );

    assign ram_we = (target == TGT_RAM) && wr_en;
    assign ram_re = (target == TGT_RAM) && rd_en && !wr_en;

    idm_ram u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (ram_we),
        .re      (ram_re),
        .addr    (eff_addr),
        .wdata   (wr_data),
        .rdata_q (ram_rdata)
    );

    always_comb begin
        st_d = '0;
        if (target == TGT_SFR) begin
            st_d.sfr_req  = 1'b1;
            st_d.sfr_we   = wr_en;
            st_d.sfr_addr = eff_addr;
            st_d.rd_sfr   = rd_en && !wr_en;
            if (wr_en) begin
                st_d.sfr_wdata = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.rd_sfr ? sfr_rdata : ram_rdata;
    assign sfr_req   = st_q.sfr_req;
    assign sfr_we    = st_q.sfr_we;
    assign sfr_addr  = st_q.sfr_addr;
    assign sfr_wdata = st_q.sfr_wdata;
endmodule

// File: rtl/idm_checker.sv
module idm_checker
    import idm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_indirect,
    input logic              reg_mode,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              sfr_req,
    input logic              sfr_we,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] sfr_rdata
);
    logic direct_upper;
    assign direct_upper = (rd_en || wr_en) && !reg_mode && !acc_indirect
                          && acc_addr[ADDR_W-1];

    p_sfr_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        direct_upper |=> (sfr_req && sfr_addr == $past(acc_addr)
                          && sfr_we == $past(wr_en)));

    p_sfr_wdata_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_upper && wr_en) |=> (sfr_wdata == $past(wr_data)));

    p_sfr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !direct_upper |=> !sfr_req);

    p_indirect_no_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && acc_indirect) |=> !sfr_req);

    p_reg_no_sfr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && reg_mode) |=> !sfr_req);

    p_sfr_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_upper && rd_en && !wr_en) |=> (rd_data == sfr_rdata));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || wr_en) |=> (rd_data == '0));
endmodule

bind idata_mem idm_checker u_idm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_addr     (acc_addr),
    .acc_indirect (acc_indirect),
    .reg_mode     (reg_mode),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .sfr_req      (sfr_req),
    .sfr_we       (sfr_we),
    .sfr_addr     (sfr_addr),
    .sfr_wdata    (sfr_wdata),
    .sfr_rdata    (sfr_rdata)
);

// File: tb/tb_idata_mem.sv
`timescale 1ns/1ps
module tb_idata_mem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] acc_addr = '0;
    logic       acc_indirect = 1'b0;
    logic       reg_mode = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [1:0] bank_sel = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sfr_req;
    logic       sfr_we;
    logic [7:0] sfr_addr;
    logic [7:0] sfr_wdata;
    logic [7:0] sfr_rdata;

    always #4 clk = ~clk;

    // SFR file stand-in: answers with a function of the address
    assign sfr_rdata = sfr_req ? (sfr_addr ^ 8'h5A) : 8'h00;

    idata_mem dut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_indirect(acc_indirect),
        .reg_mode(reg_mode), .reg_sel(reg_sel), .bank_sel(bank_sel),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sfr_req(sfr_req), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    int ref_mem [256];

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One access: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input string tag, input bit rd, input bit wr, input bit ind,
                        input bit rm, input int a, input int rs, input int bk, input int wd);
        int ea;
        bit to_sfr;
        int e_rd, e_req, e_we, e_addr, e_wd;
        acc_addr = a[7:0]; acc_indirect = ind; reg_mode = rm;
        reg_sel = rs[2:0]; bank_sel = bk[1:0];
        rd_en = rd; wr_en = wr; wr_data = wd[7:0];
        ea = rm ? (bk * 8 + rs) : a;
        to_sfr = (rd || wr) && !rm && !ind && (ea >= 128);
        @(posedge clk);
        e_rd = 0; e_req = 0; e_we = 0; e_addr = 0; e_wd = 0;
        if (to_sfr) begin
            e_req = 1; e_we = wr; e_addr = ea;
            e_wd = wr ? (wd & 255) : 0;
            if (rd && !wr) e_rd = ea ^ 'h5A;
        end else if (wr) begin
            ref_mem[ea] = wd & 255;
        end else if (rd) begin
            e_rd = ref_mem[ea];
        end
        @(negedge clk);
        check(tag, "rd_data", int'(rd_data), e_rd);
        check("R10", "sfr_req", int'(sfr_req), e_req);
        if (e_req == 1) begin
            check("R4", "sfr_addr", int'(sfr_addr), e_addr);
            check("R4", "sfr_we", int'(sfr_we), e_we);
            check("R4", "sfr_wdata", int'(sfr_wdata), e_wd);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 0;
        repeat (3) @(negedge clk);
        check("R1", "rd_data in reset", int'(rd_data), 0);
        check("R1", "sfr_req in reset", int'(sfr_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rd_data after reset", int'(rd_data), 0);
        check("R1", "sfr_req after reset", int'(sfr_req), 0);

        // R1: full RAM reads zero after reset
        for (int i = 0; i < 256; i++) step("R1", 1, 0, 1, 0, i, 0, 0, 0);

        // R2: lower half via both modes
        for (int i = 0; i < 128; i += 9) begin
            step("R2", 0, 1, i % 2, 0, i, 0, 0, i + 'h31);
            step("R2", 1, 0, 0, 0, i, 0, 0, 0);
            step("R2", 1, 0, 1, 0, i, 0, 0, 0);
        end

        // R3: upper RAM through indirect accesses
        for (int i = 128; i < 256; i += 7) step("R3", 0, 1, 1, 0, i, 0, 0, i ^ 'hC3);
        for (int i = 128; i < 256; i += 7) step("R3", 1, 0, 1, 0, i, 0, 0, 0);

        // R4/R8/R5: direct accesses to the same addresses go to the SFR port
        for (int i = 128; i < 256; i += 7) begin
            step("R4", 0, 1, 0, 0, i, 0, 0, 'hEE);
            step("R8", 1, 0, 0, 0, i, 0, 0, 0);
            step("R5", 1, 0, 1, 0, i, 0, 0, 0);
        end

        // R6: register operands across all banks, cross-read by address
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r++) begin
                step("R6", 0, 1, 0, 1, 'hFF, r, b, b * 16 + r + 1);
            end
        end
        for (int k = 0; k < 32; k++) step("R6", 1, 0, 0, 0, k, 0, 0, 0);
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r++) step("R6", 1, 0, b % 2, 1, 'hA0 + r, r, b, 0);
        end

        // R7: write then immediate read back, back to back
        step("R7", 0, 1, 1, 0, 'h40, 0, 0, 'h9C);
        step("R7", 1, 0, 0, 0, 'h40, 0, 0, 0);
        step("R7", 1, 0, 1, 0, 'hF0, 0, 0, 0);

        // R9: idle and simultaneous strobes
        step("R9", 0, 0, 0, 0, 'h40, 0, 0, 0);
        step("R9", 1, 1, 1, 0, 'h41, 0, 0, 'h77);
        step("R9", 1, 1, 0, 0, 'h90, 0, 0, 'h66);
        step("R9", 1, 0, 1, 0, 'h41, 0, 0, 0);

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            step("R7", $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                 ($urandom_range(0, 3) == 0), $urandom_range(0, 255),
                 $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 255));
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule